// File: doc/BRIEF.md
# Byte Cache Controller with Selectable Write Policy

This block sits between a processor's byte load/store port and a slow backing memory. It holds a small set-associative array of lines. Each line has a valid flag, a dirty flag, a tag and `2**OFF_W` data bytes. A processor request is accepted while `cpu_ready_o` is high. The controller looks the address up and answers with one `cpu_valid_o` pulse that carries a byte.

On a miss the controller always brings the whole line in before it completes the access, for loads and stores alike. The line is fetched one byte per memory handshake, starting from the lowest offset. The elaboration parameter `WRITE_BACK` picks the write policy:
- In write-through mode every store also writes its byte to memory, and eviction never writes anything.
- In write-back mode a store only marks the line dirty. A dirty line is copied back to memory before it is replaced.

The way to replace comes from an external selector. With a single way it is always the indexed line. Four running counters report hits, misses, memory reads and memory writes.

Top module: `cache_wpolicy_ctrl`

## Requirements
- R1: After reset `cpu_ready_o`=1, `cpu_valid_o`=0, `mem_req_o`=0, all four counters are 0 and every line is invalid, so the first access to any address misses.
- R2: The address is split from the LSB upward: bits `[OFF_W-1:0]` are the byte offset, the next `IDX_W` bits are the set index and the remaining upper bits are the tag. An access hits only if a valid way of its set holds its tag.
- R3: A hit makes no memory request. When the request is accepted at clock edge E, `cpu_valid_o` is high for exactly the one cycle after edge E+1 (write-back hit, or write-through load hit). The hit counter then increments. The response byte is the line byte at the offset; for a store it is the byte just written.
- R4: A miss increments the miss counter and reads the line from memory, one byte per acknowledged request. The reads go in ascending offset from the line base (`mem_we_o`=0), and each one increments the memory-read counter. The controller then looks the line up again (that lookup is not counted as a hit) and responds.
- R5: A store that misses allocates the line: the fill completes first, then the store byte is merged into the line.
- R6: Write-through (`WRITE_BACK`=0): every store, hit or miss, issues one memory write of its byte to its own address (`mem_we_o`=1) after the line is updated. The write completes before the response. Evictions never write to memory.
- R7: Write-back (`WRITE_BACK`=1): a fill leaves the line valid and clean, and a store sets the line dirty. Evicting a clean line only invalidates it. Evicting a dirty line first writes all of its bytes to the old line address in ascending offset, and then the fill starts.
- R8: On a miss the victim is `victim_way_i`, sampled in the lookup cycle; with `WAYS`=1 it is way 0. On a hit `victim_way_i` is ignored.
- R9: `cpu_ready_o` is high only while the controller is idle. A request is taken only when `cpu_ready_o` is high, and `cpu_ready_o` drops in the following cycle.
- R10: A memory request keeps `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` unchanged until the cycle in which `mem_ack_i` is high. Each acknowledged cycle transfers one byte.
- R11: `hit_cnt_o`, `miss_cnt_o`, `mem_rd_cnt_o` and `mem_wr_cnt_o` count hits, misses, acknowledged memory reads and acknowledged memory writes, and never decrease.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor access request |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Byte address |
| cpu_wdata_i | input | DATA_W | Store byte |
| cpu_ready_o | output | 1 | Controller idle, request can be taken |
| cpu_valid_o | output | 1 | Response pulse |
| cpu_rdata_o | output | DATA_W | Response byte |
| victim_way_i | input | WAY_W | Replacement choice for a miss |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write byte |
| mem_ack_i | input | 1 | Memory handshake completes this cycle |
| mem_rdata_i | input | DATA_W | Memory read byte, valid with ack |
| hit_cnt_o | output | CNT_W | Hit count |
| miss_cnt_o | output | CNT_W | Miss count |
| mem_rd_cnt_o | output | CNT_W | Memory read count |
| mem_wr_cnt_o | output | CNT_W | Memory write count |

## Verification
The bench builds two copies side by side with the default geometry: a 5-bit address, 2-byte lines, 2 sets and 2 ways. One copy has `WRITE_BACK`=1 and the other `WRITE_BACK`=0, and both receive the same access trace. Because the cache is this small, a short trace is enough to cause set conflicts, and the bench chooses the victim way on each access. That brings clean and dirty evictions, store allocation, write-through traffic and victim selection within reach. The bench's memory charges four cycles for the first byte of a burst and one cycle for each following byte, so the response latency shows every write-back and fill.

// File: rtl/cache_ctrl_pkg.sv
package cache_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_FILL,
    ST_RESPOND
  } cc_state_e;
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 3,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]       valid_i,
  input  logic [WAYS*TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]      tag_i,
  output logic                  hit_o,
  output logic [WAY_W-1:0]      way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
  end

  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        hit_o = 1'b1;
        way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
  parameter int WAYS   = 2,
  parameter int IDX_W  = 1,
  parameter int OFF_W  = 1,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 8,
  parameter int WAY_W  = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IDX_W-1:0]      set_i,
  output logic [WAYS-1:0]       valid_o,
  output logic [WAYS-1:0]       dirty_o,
  output logic [WAYS*TAG_W-1:0] tags_o,
  input  logic [WAY_W-1:0]      rd_way_i,
  input  logic [OFF_W-1:0]      rd_off_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic                  wr_en_i,
  input  logic [WAY_W-1:0]      wr_way_i,
  input  logic [OFF_W-1:0]      wr_off_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  meta_en_i,
  input  logic [WAY_W-1:0]      meta_way_i,
  input  logic                  meta_valid_i,
  input  logic                  meta_dirty_i,
  input  logic [TAG_W-1:0]      meta_tag_i
);
  localparam int SETS   = 1 << IDX_W;
  localparam int LINE_B = 1 << OFF_W;

  logic [DATA_W-1:0] data_q  [WAYS][SETS][LINE_B];
  logic              valid_q [WAYS][SETS];
  logic              dirty_q [WAYS][SETS];
  logic [TAG_W-1:0]  tag_q   [WAYS][SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign valid_o[w]                 = valid_q[w][set_i];
    assign dirty_o[w]                 = dirty_q[w][set_i];
    assign tags_o[w*TAG_W +: TAG_W]   = tag_q[w][set_i];
  end

  assign rd_data_o = data_q[rd_way_i][set_i][rd_off_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++) begin
        for (int s = 0; s < SETS; s++) begin
          valid_q[w][s] <= 1'b0;
          dirty_q[w][s] <= 1'b0;
          tag_q[w][s]   <= '0;
        end
      end
    end else if (meta_en_i) begin
      valid_q[meta_way_i][set_i] <= meta_valid_i;
      dirty_q[meta_way_i][set_i] <= meta_dirty_i;
      tag_q[meta_way_i][set_i]   <= meta_tag_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[wr_way_i][set_i][wr_off_i] <= wr_data_i;
  end
endmodule

// File: rtl/cache_wpolicy_ctrl.sv
module cache_wpolicy_ctrl
  import cache_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int OFF_W      = 1,
  parameter int IDX_W      = 1,
  parameter int WAYS       = 2,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter bit WRITE_BACK = 1'b1,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_valid_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic [WAY_W-1:0]  victim_way_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o,
  output logic [CNT_W-1:0]  mem_rd_cnt_o,
  output logic [CNT_W-1:0]  mem_wr_cnt_o
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  cc_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WAY_W-1:0]  way_q, way_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [TAG_W-1:0]  evict_tag_q, evict_tag_d;
  logic              refill_q, refill_d;
  logic              single_q, single_d;
  logic [CNT_W-1:0]  hit_cnt_q, miss_cnt_q, rd_cnt_q, wr_cnt_q;
  logic              inc_hit, inc_miss, inc_rd, inc_wr;

  logic [OFF_W-1:0]  off_q;
  logic [IDX_W-1:0]  set_q;
  logic [TAG_W-1:0]  tag_q;
  assign off_q = addr_q[OFF_W-1:0];
  assign set_q = addr_q[OFF_W +: IDX_W];
  assign tag_q = addr_q[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]       line_valid, line_dirty;
  logic [WAYS*TAG_W-1:0] line_tags;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way, victim_sel;
  logic [OFF_W-1:0]      rd_off;
  logic [DATA_W-1:0]     rd_byte;
  logic                  wr_en, meta_en, meta_valid, meta_dirty;
  logic [WAY_W-1:0]      wr_way;
  logic [OFF_W-1:0]      wr_off;
  logic [DATA_W-1:0]     wr_data;
  logic [TAG_W-1:0]      meta_tag;
  logic                  last_word;

  if (WAYS > 1) begin : g_assoc
    assign victim_sel = victim_way_i;
  end else begin : g_direct
    assign victim_sel = '0;
  end

  cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .valid_i(line_valid), .tags_i(line_tags), .tag_i(tag_q),
    .hit_o(hit), .way_o(hit_way)
  );

  cache_line_store #(
    .WAYS(WAYS), .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .WAY_W(WAY_W)
  ) u_store (
    .clk_i, .rst_ni, .set_i(set_q),
    .valid_o(line_valid), .dirty_o(line_dirty), .tags_o(line_tags),
    .rd_way_i(way_q), .rd_off_i(rd_off), .rd_data_o(rd_byte),
    .wr_en_i(wr_en), .wr_way_i(wr_way), .wr_off_i(wr_off), .wr_data_i(wr_data),
    .meta_en_i(meta_en), .meta_way_i(wr_way), .meta_valid_i(meta_valid),
    .meta_dirty_i(meta_dirty), .meta_tag_i(meta_tag)
  );

  assign last_word   = (cnt_q == {OFF_W{1'b1}});
  assign rd_off      = (state_q == ST_WRITEBACK) ? cnt_q : off_q;
  assign cpu_ready_o = (state_q == ST_IDLE);
  assign cpu_valid_o = (state_q == ST_RESPOND);
  assign cpu_rdata_o = rd_byte;

  always_comb begin
    state_d     = state_q;
    way_d       = way_q;
    cnt_d       = cnt_q;
    evict_tag_d = evict_tag_q;
    refill_d    = refill_q;
    single_d    = single_q;
    inc_hit     = 1'b0;
    inc_miss    = 1'b0;
    inc_rd      = 1'b0;
    inc_wr      = 1'b0;
    wr_en       = 1'b0;
    wr_way      = way_q;
    wr_off      = off_q;
    wr_data     = wdata_q;
    meta_en     = 1'b0;
    meta_valid  = 1'b0;
    meta_dirty  = 1'b0;
    meta_tag    = tag_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = {tag_q, set_q, cnt_q};
    mem_wdata_o = '0;
    unique case (state_q)
      ST_IDLE: if (cpu_req_i) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        refill_d = 1'b0;
        if (hit) begin
          inc_hit = !refill_q;
          way_d   = hit_way;
          wr_way  = hit_way;
          if (we_q) begin
            wr_en      = 1'b1;
            meta_en    = 1'b1;
            meta_valid = 1'b1;
            meta_dirty = WRITE_BACK;
          end
          single_d = 1'b1;
          state_d  = (!WRITE_BACK && we_q) ? ST_WRITEBACK : ST_RESPOND;
        end else begin
          inc_miss    = 1'b1;
          way_d       = victim_sel;
          wr_way      = victim_sel;
          evict_tag_d = line_tags[victim_sel*TAG_W +: TAG_W];
          cnt_d       = '0;
          single_d    = 1'b0;
          if (WRITE_BACK && line_valid[victim_sel] && line_dirty[victim_sel]) begin
            state_d = ST_WRITEBACK;
          end else begin
            meta_en = 1'b1;
            state_d = ST_FILL;
          end
        end
      end
      ST_WRITEBACK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = single_q ? addr_q : {evict_tag_q, set_q, cnt_q};
        mem_wdata_o = single_q ? wdata_q : rd_byte;
        if (mem_ack_i) begin
          inc_wr = 1'b1;
          if (single_q) begin
            state_d = ST_RESPOND;
          end else if (last_word) begin
            meta_en = 1'b1;
            cnt_d   = '0;
            state_d = ST_FILL;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          inc_rd  = 1'b1;
          wr_en   = 1'b1;
          wr_off  = cnt_q;
          wr_data = mem_rdata_i;
          if (last_word) begin
            meta_en    = 1'b1;
            meta_valid = 1'b1;
            refill_d   = 1'b1;
            state_d    = ST_LOOKUP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      way_q       <= '0;
      cnt_q       <= '0;
      evict_tag_q <= '0;
      refill_q    <= 1'b0;
      single_q    <= 1'b0;
      hit_cnt_q   <= '0;
      miss_cnt_q  <= '0;
      rd_cnt_q    <= '0;
      wr_cnt_q    <= '0;
    end else begin
      state_q     <= state_d;
      way_q       <= way_d;
      cnt_q       <= cnt_d;
      evict_tag_q <= evict_tag_d;
      refill_q    <= refill_d;
      single_q    <= single_d;
      if (state_q == ST_IDLE && cpu_req_i) begin
        addr_q  <= cpu_addr_i;
        we_q    <= cpu_we_i;
        wdata_q <= cpu_wdata_i;
      end
      if (inc_hit)  hit_cnt_q  <= hit_cnt_q + 1'b1;
      if (inc_miss) miss_cnt_q <= miss_cnt_q + 1'b1;
      if (inc_rd)   rd_cnt_q   <= rd_cnt_q + 1'b1;
      if (inc_wr)   wr_cnt_q   <= wr_cnt_q + 1'b1;
    end
  end

  assign hit_cnt_o    = hit_cnt_q;
  assign miss_cnt_o   = miss_cnt_q;
  assign mem_rd_cnt_o = rd_cnt_q;
  assign mem_wr_cnt_o = wr_cnt_q;
endmodule

// File: rtl/cache_wpolicy_ctrl_chk.sv
module cache_wpolicy_ctrl_chk #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_ready_o,
  input logic              cpu_valid_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic [CNT_W-1:0]  hit_cnt_o,
  input logic [CNT_W-1:0]  miss_cnt_o
);
  assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !cpu_ready_o);

  assert_accept_drops_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_ready_o |=> !cpu_ready_o);

  assert_req_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));

  assert_resp_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_o |=> !cpu_valid_o && cpu_ready_o);

  // R6: a write-through store write is a single transfer followed by the response
  assert_wt_single_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !WRITE_BACK && mem_req_o && mem_we_o && mem_ack_i |=> !mem_req_o && cpu_valid_o);

  assert_counts_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cnt_o != $past(hit_cnt_o)) |-> (miss_cnt_o == $past(miss_cnt_o)));
endmodule

bind cache_wpolicy_ctrl cache_wpolicy_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WRITE_BACK(WRITE_BACK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_ready_o(cpu_ready_o),
  .cpu_valid_o(cpu_valid_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o)
);

// File: tb/cache_wpolicy_ctrl_test.sv
module cache_wpolicy_ctrl_test;
  localparam int LINE_B = 2, WAYS = 2, FIRST_LAT = 4, NEXT_LAT = 1, MEM_SZ = 32;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic       cpu_req, cpu_we, victim;
  logic [4:0] cpu_addr;
  logic [7:0] cpu_wdata;
  logic       ready [2], valid [2], mreq [2], mwe [2], mack [2];
  logic [7:0] rdata [2], mwdata [2], mrdata [2];
  logic [4:0] maddr [2];
  logic [15:0] hcnt [2], mcnt [2], rcnt [2], wcnt [2];

  // index 0: write-through, index 1: write-back
  cache_wpolicy_ctrl #(.WRITE_BACK(1'b0)) uut_wt (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_ready_o(ready[0]),
    .cpu_valid_o(valid[0]), .cpu_rdata_o(rdata[0]), .victim_way_i(victim),
    .mem_req_o(mreq[0]), .mem_we_o(mwe[0]), .mem_addr_o(maddr[0]), .mem_wdata_o(mwdata[0]),
    .mem_ack_i(mack[0]), .mem_rdata_i(mrdata[0]), .hit_cnt_o(hcnt[0]), .miss_cnt_o(mcnt[0]),
    .mem_rd_cnt_o(rcnt[0]), .mem_wr_cnt_o(wcnt[0]));

  cache_wpolicy_ctrl #(.WRITE_BACK(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_ready_o(ready[1]),
    .cpu_valid_o(valid[1]), .cpu_rdata_o(rdata[1]), .victim_way_i(victim),
    .mem_req_o(mreq[1]), .mem_we_o(mwe[1]), .mem_addr_o(maddr[1]), .mem_wdata_o(mwdata[1]),
    .mem_ack_i(mack[1]), .mem_rdata_i(mrdata[1]), .hit_cnt_o(hcnt[1]), .miss_cnt_o(mcnt[1]),
    .mem_rd_cnt_o(rcnt[1]), .mem_wr_cnt_o(wcnt[1]));

  int n_chk = 0, n_bad = 0;

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int op_code(int we, int a, int d);
    return (we << 16) | (a << 8) | (d & 255);
  endfunction

  // behavioural memory with burst timing
  logic [7:0] mem [2][MEM_SZ];
  logic [7:0] ref_mem [2][MEM_SZ];
  int wait_c [2], burst [2], paddr [2], pwe [2], hold [2];
  int op_q [2][$];
  int exp_q [2][$];

  task automatic mem_step();
    for (int m = 0; m < 2; m++) begin
      mack[m] = 1'b0;
      if (mreq[m]) begin
        if (wait_c[m] == 0) begin
          wait_c[m] = (burst[m] != 0 && pwe[m] == int'(mwe[m]) &&
                       int'(maddr[m]) == ((paddr[m] + 1) % MEM_SZ)) ? NEXT_LAT : FIRST_LAT;
          hold[m] = op_code(int'(mwe[m]), int'(maddr[m]), mwe[m] ? int'(mwdata[m]) : 0);
        end
        wait_c[m]--;
        if (wait_c[m] == 0) begin
          check("R10 request held until ack",
                op_code(int'(mwe[m]), int'(maddr[m]), mwe[m] ? int'(mwdata[m]) : 0), hold[m]);
          if (mwe[m]) begin
            mem[m][maddr[m]] = mwdata[m];
            op_q[m].push_back(op_code(1, int'(maddr[m]), int'(mwdata[m])));
          end else begin
            mrdata[m] = mem[m][maddr[m]];
            op_q[m].push_back(op_code(0, int'(maddr[m]), int'(mem[m][maddr[m]])));
          end
          mack[m]  = 1'b1;
          burst[m] = 1;
          paddr[m] = int'(maddr[m]);
          pwe[m]   = int'(mwe[m]);
        end
      end else begin
        burst[m] = 0;
      end
    end
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      mack[m] = 1'b0; mrdata[m] = '0; wait_c[m] = 0; burst[m] = 0;
      for (int i = 0; i < MEM_SZ; i++) begin
        mem[m][i]     = 8'((i * 37 + 11) & 255);
        ref_mem[m][i] = 8'((i * 37 + 11) & 255);
      end
    end
    forever begin
      @(negedge clk);
      mem_step();
    end
  end

  // reference cache state
  int mv [2][WAYS][2], md [2][WAYS][2], mt [2][WAYS][2], mdat [2][WAYS][2][LINE_B];
  int hits [2], misses [2], rds [2], wrs [2];

  task automatic model(int m, int we, int a, int wd, int vic, output int lat, output int rd);
    int tg, st, off, w, base;
    tg = a >> 2; st = (a >> 1) & 1; off = a & 1; w = -1;
    for (int i = 0; i < WAYS; i++) if (mv[m][i][st] != 0 && mt[m][i][st] == tg) w = i;
    lat = 1;
    if (w < 0) begin
      misses[m]++;
      w = vic;
      if (m == 1 && mv[m][w][st] != 0 && md[m][w][st] != 0) begin
        base = (mt[m][w][st] << 2) | (st << 1);
        for (int o = 0; o < LINE_B; o++) begin
          exp_q[m].push_back(op_code(1, base + o, mdat[m][w][st][o]));
          ref_mem[m][base + o] = 8'(mdat[m][w][st][o]);
          wrs[m]++;
        end
        lat += FIRST_LAT + NEXT_LAT * (LINE_B - 1);
      end
      base = (tg << 2) | (st << 1);
      for (int o = 0; o < LINE_B; o++) begin
        exp_q[m].push_back(op_code(0, base + o, int'(ref_mem[m][base + o])));
        mdat[m][w][st][o] = int'(ref_mem[m][base + o]);
        rds[m]++;
      end
      lat += FIRST_LAT + NEXT_LAT * (LINE_B - 1) + 1;
      mv[m][w][st] = 1; md[m][w][st] = 0; mt[m][w][st] = tg;
    end else begin
      hits[m]++;
    end
    if (we != 0) begin
      mdat[m][w][st][off] = wd;
      if (m == 1) md[m][w][st] = 1;
      else begin
        exp_q[m].push_back(op_code(1, a, wd));
        ref_mem[m][a] = 8'(wd);
        wrs[m]++;
        lat += FIRST_LAT;
      end
    end
    rd = mdat[m][w][st][off];
  endtask

  task automatic access(int we, int a, int wd, int vic);
    int lat [2], rdv [2], got [2], exl [2], exr [2];
    int k;
    for (int m = 0; m < 2; m++) begin
      op_q[m].delete(); exp_q[m].delete();
      got[m] = 0; lat[m] = -1; rdv[m] = -1;
      model(m, we, a, wd, vic, exl[m], exr[m]);
    end
    k = 0;
    while (!(ready[0] && ready[1]) && k < 100) begin @(negedge clk); k++; end
    cpu_req = 1'b1; cpu_we = we[0]; cpu_addr = a[4:0]; cpu_wdata = wd[7:0]; victim = vic[0];
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    for (int m = 0; m < 2; m++) check($sformatf("R9 ready low after accept m%0d", m), ready[m], 0);
    k = 0;
    while (!(got[0] != 0 && got[1] != 0) && k < 200) begin
      @(posedge clk); k++;
      @(negedge clk);
      for (int m = 0; m < 2; m++)
        if (got[m] == 0 && valid[m]) begin got[m] = 1; lat[m] = k; rdv[m] = int'(rdata[m]); end
    end
    for (int m = 0; m < 2; m++) begin
      if (got[m] == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R3 watchdog no response m%0d actual=none expected=response", m);
      end
      check($sformatf("R2 R3 R4 latency m%0d addr %0d", m, a), lat[m], exl[m]);
      check($sformatf("R3 R5 response byte m%0d addr %0d", m, a), rdv[m], exr[m]);
      check($sformatf("R4 R6 R7 R8 mem op count m%0d addr %0d", m, a), op_q[m].size(), exp_q[m].size());
      for (int i = 0; i < op_q[m].size() && i < exp_q[m].size(); i++)
        check($sformatf("R4 R6 R7 mem op %0d m%0d addr %0d", i, m, a), op_q[m][i], exp_q[m][i]);
      check($sformatf("R11 hit count m%0d", m), hcnt[m], hits[m]);
      check($sformatf("R11 miss count m%0d", m), mcnt[m], misses[m]);
      check($sformatf("R11 read count m%0d", m), rcnt[m], rds[m]);
      check($sformatf("R11 write count m%0d", m), wcnt[m], wrs[m]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R3 global watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      hits[m] = 0; misses[m] = 0; rds[m] = 0; wrs[m] = 0;
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < 2; s++) begin
          mv[m][w][s] = 0; md[m][w][s] = 0; mt[m][w][s] = 0;
          for (int o = 0; o < LINE_B; o++) mdat[m][w][s][o] = 0;
        end
    end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; victim = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check("R1 reset ready", ready[m], 1);
      check("R1 reset valid", valid[m], 0);
      check("R1 reset mem request", mreq[m], 0);
      check("R1 reset counters", {hcnt[m], mcnt[m]} | {rcnt[m], wcnt[m]}, 0);
    end
    access(0, 1, 0, 0);       // R1 cold miss, set 0 way 0
    access(0, 13, 0, 1);      // R8 set 0 way 1, tag 3
    access(0, 0, 0, 1);       // R3 hit, victim ignored
    access(1, 0, 8'hA5, 0);   // store hit, dirty in write-back
    access(1, 6, 8'h5A, 0);   // R5 store miss allocates set 1
    access(0, 8, 0, 0);       // R7 dirty eviction of way 0
    access(0, 0, 0, 1);       // clean eviction of tag 3, reads stored byte back
    access(0, 6, 0, 1);       // hit on allocated store
    access(1, 7, 8'h3C, 1);   // store hit
    access(0, 31, 0, 1);      // fill into invalid way 1 of set 1
    access(0, 23, 0, 0);      // R7 dirty eviction of line 6..7
    access(0, 7, 0, 1);       // store data returned via memory
    access(1, 9, 8'h77, 0);   // R6 store hit
    access(0, 17, 0, 1);      // R2 same set, new tag
    access(0, 9, 0, 0);       // R8 hit regardless of victim
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule